// File: doc/BRIEF.md
# Registered Handshake Pipeline Slice

This block sits between a producer and a consumer that both use a valid/ready/data handshake. It cuts every combinational path through the link. The ready it offers upstream is a register output, and so are the valid and the data it presents downstream. A long chain of such slices therefore never forms a loop, and timing never has to span a round trip across it.

Throughput is not lost. With the consumer always ready, a word moves through on every cycle. A second holding register catches the single word that is already on its way when the consumer stalls. Only after that word is caught does the slice withdraw its ready, one cycle later. When the consumer takes a word again, the caught word moves forward and the slice reopens. Words leave in arrival order.

Top module: `hs_reg_slice`

## Requirements
- R1: While `rst` is high at a rising clock edge, the slice becomes empty: after that edge `dn_valid` is 0 and `up_ready` is 1.
- R2: Whenever the slice holds no word (`dn_valid` low), `up_ready` is high, without waiting for `up_valid`, so an upstream word is accepted in the first cycle it is offered.
- R3: A word is taken only on a rising edge where `up_valid` and `up_ready` are both 1. Data presented with `up_valid` low never reaches the output.
- R4: Once `dn_valid` is high, it stays high and `dn_data` stays unchanged until an edge where `dn_ready` is also high.
- R5: With `dn_ready` held high, a stream of words offered on consecutive cycles is accepted on consecutive cycles, with no stall.
- R6: If a word is taken while the slice already holds a word and `dn_ready` is low, the extra word is kept and `up_ready` is low in the following cycle.
- R7: While `up_ready` is low, an edge with `dn_ready` high delivers the older word. After that edge `up_ready` is high again, and `dn_data` shows the kept word.
- R8: Words appear on `dn_data` in the order they were taken, each exactly once, under any pattern of `up_valid` gaps and `dn_ready` stalls.
- R9: `up_ready` does not change with `up_valid` or `dn_ready` within a cycle, and `dn_valid` does not change with `up_valid` or `dn_ready` within a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Upstream has a word on `up_data` |
| up_ready | output | 1 | Slice can take a word (registered) |
| up_data | input | W | Upstream word |
| dn_valid | output | 1 | Slice presents a word on `dn_data` (registered) |
| dn_ready | input | 1 | Downstream takes the presented word |
| dn_data | output | W | Presented word (registered) |

## Verification
The hard case to reach is the kept-word state. It needs a word to arrive on the exact edge where the main register is full and the consumer is stalling, followed by a release of that stall. The stimulus builds this directly. It stalls the consumer, offers two words back to back, and then opens `dn_ready` for exactly one cycle. This observes the drop of `up_ready` and its return. It also probes the same full state mid-cycle, toggling `up_valid` and `dn_ready` to confirm that the outputs do not move. Long random runs then mix consumer stalls of varying density with gaps in the offered stream. A queue scoreboard catches any reordered, duplicated or lost word.

// File: rtl/hs_reg_slice.sv
module hs_reg_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         main_full, side_full;
  logic [W-1:0] main_q, side_q;

  wire take = up_valid & ~side_full;
  wire give = main_full & dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_full <= 1'b0;
      side_full <= 1'b0;
    end else if (side_full) begin
      if (give) side_full <= 1'b0;
    end else if (take) begin
      main_full <= 1'b1;
      if (main_full && !give) side_full <= 1'b1;
    end else if (give) begin
      main_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (side_full) begin
      if (give) main_q <= side_q;
    end else if (take) begin
      if (!main_full || give) main_q <= up_data;
      else                    side_q <= up_data;
    end
  end

  assign up_ready = ~side_full;
  assign dn_valid = main_full;
  assign dn_data  = main_q;

endmodule

// File: rtl/hs_reg_slice_chk.sv
module hs_reg_slice_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         up_valid,
  input logic         up_ready,
  input logic         dn_valid,
  input logic         dn_ready,
  input logic [W-1:0] dn_data
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!dn_valid && up_ready));

  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !dn_valid |-> up_ready);

  a_r3_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (!dn_valid && !(up_valid && up_ready)) |=> !dn_valid);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  a_r6_skid_fills: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready && up_valid && up_ready) |=> !up_ready);

  a_r7_reopen: assert property (@(posedge clk) disable iff (rst)
    (!up_ready && dn_ready) |=> up_ready);

  a_r8_kept_behind_main: assert property (@(posedge clk) disable iff (rst)
    !up_ready |-> dn_valid);

endmodule

bind hs_reg_slice hs_reg_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
);

// File: tb/tb_hs_reg_slice.sv
module tb_hs_reg_slice;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1, up_valid = 1'b0, dn_ready = 1'b0;
  logic [W-1:0] up_data = '0;
  logic up_ready, dn_valid;
  logic [W-1:0] dn_data;

  int checks = 0, errors = 0, rmode = 0, pops = 0;
  bit done = 1'b0, hold_pend = 1'b0;
  logic [W-1:0] hold_d = '0;
  logic [W-1:0] exp_q[$];

  hs_reg_slice #(.W(W)) dut (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // downstream ready pattern: 0 low, 1 high, 2 mostly high, 3 mostly low
  always @(posedge clk) begin
    #1;
    case (rmode)
      1: dn_ready = 1'b1;
      2: dn_ready = ($urandom % 3) != 0;
      3: dn_ready = ($urandom % 8) == 0;
      default: dn_ready = 1'b0;
    endcase
  end

  // monitor: pop and compare on every downstream transfer
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) chk(dn_valid && dn_data == hold_d, "R4", {15'd0, dn_valid, dn_data}, {16'd1, hold_d});
      hold_pend = dn_valid && !dn_ready;
      hold_d = dn_data;
      if (dn_valid && dn_ready) begin
        pops++;
        if (exp_q.size() == 0) chk(1'b0, "R8", dn_data, 0);
        else begin
          chk(dn_data == exp_q[0], "R8", dn_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // entered just after a rising edge; returns on the edge that takes the word
  task automatic send(input logic [W-1:0] d, output int waits);
    waits = 0;
    #1;
    up_valid = 1'b1;
    up_data = d;
    forever begin
      @(negedge clk);
      if (up_ready) begin
        @(posedge clk);
        exp_q.push_back(d);
        break;
      end
      @(posedge clk);
      waits++;
    end
  endtask

  task automatic idle(input int n);
    #1;
    up_valid = 1'b0;
    up_data = W'($urandom);
    repeat (n) @(posedge clk);
  endtask

  // called just after a falling edge: inputs toggle mid-cycle, outputs must not move
  task automatic probe(input string tag);
    logic r0, v0;
    #2;
    r0 = up_ready;
    v0 = dn_valid;
    up_valid = ~up_valid;
    dn_ready = ~dn_ready;
    #2;
    chk(up_ready == r0, "R9", {31'd0, up_ready}, {31'd0, r0});
    chk(dn_valid == v0, "R9", {31'd0, dn_valid}, {31'd0, v0});
    up_valid = ~up_valid;
    dn_ready = ~dn_ready;
    if (tag == "") ;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w, tot;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!dn_valid, "R1", {31'd0, dn_valid}, 0);
    chk(up_ready, "R1", {31'd0, up_ready}, 1);
    chk(up_ready, "R2", {31'd0, up_ready}, 1);
    probe("empty");
    @(posedge clk);

    // R3: data without valid is ignored
    repeat (4) idle(1);
    @(negedge clk);
    chk(!dn_valid, "R3", {31'd0, dn_valid}, 0);
    @(posedge clk);

    // R6 / R7: fill main and kept word under a stall
    rmode = 0;
    send(16'hA001, w);
    chk(w == 0, "R2", w, 0);
    send(16'hB002, w);
    chk(w == 0, "R6", w, 0);
    idle(0);
    @(negedge clk);
    chk(!up_ready, "R6", {31'd0, up_ready}, 0);
    chk(dn_valid && dn_data == 16'hA001, "R4", dn_data, 16'hA001);
    probe("full");
    rmode = 1;
    @(negedge clk);
    rmode = 0;
    @(negedge clk);
    chk(up_ready, "R7", {31'd0, up_ready}, 1);
    chk(dn_valid && dn_data == 16'hB002, "R7", dn_data, 16'hB002);
    rmode = 1;
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    // R5: full rate with downstream always ready
    tot = 0;
    for (int i = 0; i < 16; i++) begin
      send(W'(16'h5000 + i), w);
      tot += w;
    end
    chk(tot == 0, "R5", tot, 0);
    idle(4);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);

    // R8: random stalls and gaps
    rmode = 2;
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) idle(1);
      send(W'($urandom), w);
    end
    rmode = 3;
    for (int i = 0; i < 120; i++) begin
      if (($urandom % 5) == 0) idle(1);
      send(W'($urandom), w);
    end
    idle(0);
    rmode = 1;
    repeat (10) @(posedge clk);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    chk(pops == 438, "R8", pops, 438);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule